// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block turns one block-transfer command (a base address, a mask naming which of the registers take part, a load or store select, one of four stack addressing modes and a writeback flag) into a run of single-word memory requests. Each request carries the word address and the index of the register it belongs to. Registers are always visited from the lowest index to the highest, and the lowest index always gets the lowest address, whatever the direction of the stack. When the run ends, the block pulses a completion strobe. If writeback was asked for, it also presents the updated base value. If the program-counter register was loaded, it also presents the loaded word as a branch target.

A core's issue logic starts a transfer with a one-cycle start strobe while the sequencer is idle. The memory side acknowledges each request with a ready signal. On a load, the read word is sampled in the same cycle as the ready. A store in full-descending mode is a stack push and a load in the same mode is the matching pop. The address arithmetic (first address and final base) is worked out once, at start, from the population count of the mask.

Top module: `lsm_addr_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `mem_req`, `done`, `wb_valid` and `branch_valid` are all low.
- R2: A started transfer issues exactly one accepted request per set bit of `start_mask`. The requests come in strictly increasing register index on `mem_reg_idx`, and `mem_write` is 1 for a store (`start_load`=0) and 0 for a load.
- R3: Each request after the first carries the address of the previous one plus 4.
- R4: With `start_mode` encoded as bit 1 = empty (1) / full (0) and bit 0 = ascending (1) / descending (0), and n the number of selected registers, the transfer runs upward when (bit 0 XOR load) is 1. It steps before the access when (NOT bit 1 XOR load) is 1. The first address is then base+4 (upward, step before), base (upward, step after), base−4n (downward, step before) or base−4n+4 (downward, step after). A full-descending store therefore starts at base−4n, and a full-descending load starts at base.
- R5: When `start_wback` is set and n>0, `wb_valid` is high in the `done` cycle, with `wb_base` equal to base+4n for an upward transfer and base−4n for a downward one. Otherwise `wb_valid` stays low.
- R6: While `mem_req` is high and `mem_ready` is low, the request, its address, its register index and its direction stay unchanged in the next cycle.
- R7: `done` is high for exactly one cycle, the cycle after the last request is accepted, and no request is pending in that cycle.
- R8: An empty mask produces no request and raises `done` in the cycle after the start strobe, without `wb_valid`.
- R9: A load whose mask includes register 15 raises `branch_valid` in the `done` cycle, with `branch_target` equal to the `mem_rdata` accepted with the register-15 request. Stores, and masks without register 15, never raise it.
- R10: A start strobe given while `busy` is high is ignored, and the running transfer continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_valid | input | 1 | One-cycle command strobe, taken only when idle |
| start_base | input | 32 | Base register value |
| start_mask | input | 16 | Register selection mask, bit i selects register i |
| start_load | input | 1 | 1 = load from memory, 0 = store to memory |
| start_mode | input | 2 | Stack mode: bit 1 empty/full, bit 0 ascending/descending |
| start_wback | input | 1 | Request an updated base at the end |
| busy | output | 1 | A transfer is in progress |
| mem_req | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the current request |
| mem_write | output | 1 | Request is a store |
| mem_addr | output | 32 | Word address of the request |
| mem_reg_idx | output | 4 | Register index of the request |
| mem_rdata | input | 32 | Read data, valid with an accepted load request |
| done | output | 1 | One-cycle completion pulse |
| wb_valid | output | 1 | Updated base is valid (with done) |
| wb_base | output | 32 | Updated base value |
| branch_valid | output | 1 | Program-counter register was loaded (with done) |
| branch_target | output | 32 | Loaded program-counter value |

## Verification
Writeback and the branch-target report both land in the single `done` cycle. The sweep provokes this by loading masks that include register 15 with writeback enabled, in every mode and under random ready stalls. In that cycle the bench requires `wb_base` to match the arithmetically expected base and `branch_target` to match the word it returned for register 15, and neither value may disturb the other. A stray start strobe during a busy transfer is also injected on ready beats, so that an ignored command and an accepted request meet at the same clock edge.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

   typedef enum logic [1:0] {
      MODE_FULL_DESC  = 2'b00,
      MODE_FULL_ASC   = 2'b01,
      MODE_EMPTY_DESC = 2'b10,
      MODE_EMPTY_ASC  = 2'b11
   } stack_mode_e;

   // Transfer moves toward higher addresses in memory order.
   function automatic logic xfer_upward(input stack_mode_e mode, input logic is_load);
      return mode[0] ^ is_load;
   endfunction

   // Address steps one word before the first access.
   function automatic logic xfer_step_first(input stack_mode_e mode, input logic is_load);
      return (~mode[1]) ^ is_load;
   endfunction

endpackage

// File: rtl/lsm_popcount.sv
module lsm_popcount #(
   parameter int W  = 16,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  bits_in,
   output logic [CW-1:0] count_out
);

   if (W < 1) begin : g_bad_width
      $error("lsm_popcount: W must be positive");
   end
   if ((1 << CW) <= W) begin : g_bad_cw
      $error("lsm_popcount: CW too narrow for W");
   end

   logic [CW-1:0] partial [W+1];

   assign partial[0] = '0;

   for (genvar g = 0; g < W; g++) begin : g_sum
      assign partial[g+1] = partial[g] + CW'(bits_in[g]);
   end

   assign count_out = partial[W];

endmodule

// File: rtl/lsm_first_set.sv
module lsm_first_set #(
   parameter int W  = 16,
   parameter int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  bits_in,
   output logic          found,
   output logic [W-1:0]  onehot,
   output logic [IW-1:0] index
);

   if (W < 2) begin : g_bad_width
      $error("lsm_first_set: W must be at least 2");
   end

   // Isolate the lowest set bit.
   assign onehot = bits_in & (~bits_in + W'(1));
   assign found  = |bits_in;

   for (genvar b = 0; b < IW; b++) begin : g_enc
      logic [W-1:0] sel;
      for (genvar i = 0; i < W; i++) begin : g_bit
         if (((i >> b) & 1) == 1) begin : g_on
            assign sel[i] = onehot[i];
         end else begin : g_off
            assign sel[i] = 1'b0;
         end
      end
      assign index[b] = |sel;
   end

endmodule

// File: rtl/lsm_addr_plan.sv
module lsm_addr_plan
   import lsm_pkg::*;
#(
   parameter int AW         = 32,
   parameter int CW         = 5,
   parameter int WORD_BYTES = 4
) (
   input  logic [AW-1:0] base,
   input  logic [CW-1:0] count,
   input  stack_mode_e   mode,
   input  logic          is_load,
   output logic [AW-1:0] first_addr,
   output logic [AW-1:0] final_base
);

   localparam int WSH = $clog2(WORD_BYTES);

   if ((1 << WSH) != WORD_BYTES) begin : g_bad_word
      $error("lsm_addr_plan: WORD_BYTES must be a power of two");
   end
   if (AW <= CW + WSH) begin : g_bad_aw
      $error("lsm_addr_plan: AW too narrow for the transfer span");
   end

   logic [AW-1:0] word;
   logic [AW-1:0] span;
   logic          upward;
   logic          step_first;

   assign word       = AW'(WORD_BYTES);
   assign span       = AW'(count) << WSH;
   assign upward     = xfer_upward(mode, is_load);
   assign step_first = xfer_step_first(mode, is_load);

   always_comb begin
      unique case ({upward, step_first})
         2'b11:   first_addr = base + word;
         2'b10:   first_addr = base;
         2'b01:   first_addr = base - span;
         default: first_addr = base - span + word;
      endcase
      final_base = upward ? (base + span) : (base - span);
   end

endmodule

// File: rtl/lsm_addr_seq.sv
module lsm_addr_seq
   import lsm_pkg::*;
#(
   parameter int NREG       = 16,
   parameter int AW         = 32,
   parameter int DW         = 32,
   parameter int WORD_BYTES = 4,
   parameter int PC_IDX     = NREG - 1,
   parameter int IW         = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_valid,
   input  logic [AW-1:0] start_base,
   input  logic [NREG-1:0] start_mask,
   input  logic          start_load,
   input  logic [1:0]    start_mode,
   input  logic          start_wback,
   output logic          busy,
   output logic          mem_req,
   input  logic          mem_ready,
   output logic          mem_write,
   output logic [AW-1:0] mem_addr,
   output logic [IW-1:0] mem_reg_idx,
   input  logic [DW-1:0] mem_rdata,
   output logic          done,
   output logic          wb_valid,
   output logic [AW-1:0] wb_base,
   output logic          branch_valid,
   output logic [DW-1:0] branch_target
);

   localparam int CW = $clog2(NREG + 1);

   if (NREG < 2 || NREG > 64) begin : g_bad_nreg
      $error("lsm_addr_seq: NREG out of range");
   end
   if (PC_IDX < 0 || PC_IDX >= NREG) begin : g_bad_pc
      $error("lsm_addr_seq: PC_IDX outside the register list");
   end
   if ((1 << IW) < NREG) begin : g_bad_iw
      $error("lsm_addr_seq: IW too narrow for NREG");
   end

   // ---------------- start-time planning ----------------
   logic [CW-1:0]   start_count;
   logic [AW-1:0]   plan_first;
   logic [AW-1:0]   plan_final;
   stack_mode_e     mode_in;

   assign mode_in = stack_mode_e'(start_mode);

   lsm_popcount #(.W(NREG), .CW(CW)) u_count (
      .bits_in   (start_mask),
      .count_out (start_count)
   );

   lsm_addr_plan #(.AW(AW), .CW(CW), .WORD_BYTES(WORD_BYTES)) u_plan (
      .base       (start_base),
      .count      (start_count),
      .mode       (mode_in),
      .is_load    (start_load),
      .first_addr (plan_first),
      .final_base (plan_final)
   );

   // ---------------- sequencing state ----------------
   logic            busy_q;
   logic [NREG-1:0] rem_q;
   logic [AW-1:0]   addr_q;
   logic            load_q;
   logic            wb_pend_q;
   logic [AW-1:0]   wb_base_q;
   logic            done_q;
   logic            wb_valid_q;
   logic            br_valid_q;
   logic [DW-1:0]   br_target_q;
   logic [CW-1:0]   beats_q;
   logic [CW-1:0]   expect_q;

   logic            pick_found;
   logic [NREG-1:0] pick_onehot;
   logic [IW-1:0]   pick_idx;

   lsm_first_set #(.W(NREG), .IW(IW)) u_pick (
      .bits_in (rem_q),
      .found   (pick_found),
      .onehot  (pick_onehot),
      .index   (pick_idx)
   );

   logic            start_fire;
   logic            accept;
   logic [NREG-1:0] rem_next;
   logic            last_beat;

   assign start_fire = start_valid & ~busy_q;
   assign accept     = mem_req & mem_ready;
   assign rem_next   = rem_q & ~pick_onehot;
   assign last_beat  = accept & ~(|rem_next);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         rem_q       <= '0;
         addr_q      <= '0;
         load_q      <= 1'b1;
         wb_pend_q   <= 1'b0;
         wb_base_q   <= '0;
         done_q      <= 1'b0;
         wb_valid_q  <= 1'b0;
         br_valid_q  <= 1'b0;
         br_target_q <= '0;
         beats_q     <= '0;
         expect_q    <= '0;
      end else begin
         done_q     <= 1'b0;
         wb_valid_q <= 1'b0;
         br_valid_q <= 1'b0;
         if (start_fire) begin
            beats_q  <= '0;
            expect_q <= start_count;
            if (start_count == '0) begin
               done_q <= 1'b1;
            end else begin
               busy_q    <= 1'b1;
               rem_q     <= start_mask;
               addr_q    <= plan_first;
               load_q    <= start_load;
               wb_pend_q <= start_wback;
               wb_base_q <= plan_final;
            end
         end else if (accept) begin
            rem_q   <= rem_next;
            addr_q  <= addr_q + AW'(WORD_BYTES);
            beats_q <= beats_q + CW'(1);
            if (load_q && (pick_idx == IW'(PC_IDX))) begin
               br_target_q <= mem_rdata;
            end
            if (last_beat) begin
               busy_q     <= 1'b0;
               done_q     <= 1'b1;
               wb_valid_q <= wb_pend_q;
               br_valid_q <= load_q & (pick_idx == IW'(PC_IDX));
            end
         end
      end
   end

   assign busy          = busy_q;
   assign mem_req       = busy_q & pick_found;
   assign mem_write     = ~load_q;
   assign mem_addr      = addr_q;
   assign mem_reg_idx   = pick_idx;
   assign done          = done_q;
   assign wb_valid      = wb_valid_q;
   assign wb_base       = wb_base_q;
   assign branch_valid  = br_valid_q;
   assign branch_target = br_target_q;

   // ---------------- assertions ----------------
   assert_idle_after_reset_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> !busy && !done && !wb_valid && !branch_valid);

   assert_index_rises_R2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !mem_req || (mem_reg_idx > $past(mem_reg_idx)));

   assert_beat_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> beats_q == expect_q);

   assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !mem_req || (mem_addr == $past(mem_addr) + AW'(WORD_BYTES)));

   assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> mem_req && $stable(mem_addr)
                                  && $stable(mem_reg_idx) && $stable(mem_write));

   assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req && !busy);

   assert_wb_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> done);

   assert_branch_on_pc_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      branch_valid |-> done && ($past(mem_reg_idx) == IW'(PC_IDX)) && !$past(mem_write));

   assert_busy_ignores_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start_valid && !accept) |=> $stable(mem_addr) && $stable(mem_reg_idx));

endmodule

// File: tb/test_lsm_addr_seq.sv
`timescale 1ns/1ps
module test_lsm_addr_seq;

   localparam int WATCHDOG = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_valid = 1'b0;
   logic [31:0] start_base = '0;
   logic [15:0] start_mask = '0;
   logic        start_load = 1'b0;
   logic [1:0]  start_mode = '0;
   logic        start_wback = 1'b0;
   logic        busy, mem_req, mem_write, done, wb_valid, branch_valid;
   logic        mem_ready = 1'b0;
   logic [31:0] mem_addr, wb_base, branch_target;
   logic [31:0] mem_rdata = '0;
   logic [3:0]  mem_reg_idx;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #10 clk = ~clk;

   lsm_addr_seq i_lsm_addr_seq (
      .clk, .rst_n, .start_valid, .start_base, .start_mask, .start_load,
      .start_mode, .start_wback, .busy, .mem_req, .mem_ready, .mem_write,
      .mem_addr, .mem_reg_idx, .mem_rdata, .done, .wb_valid, .wb_base,
      .branch_valid, .branch_target
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic step_lfsr();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == WATCHDOG) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WATCHDOG);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   task automatic run_xfer(input logic [31:0] base, input logic [15:0] mask,
                           input bit ld, input logic [1:0] mode, input bit wb,
                           input int dens);
      int          n = 0;
      int          idx_list [16];
      bit          up, pre;
      logic [31:0] first, wbexp, last_rd;
      int          beats = 0;
      int          guard = 0;
      bit          seen_done = 0;
      for (int i = 0; i < 16; i++) begin
         if (mask[i]) begin
            idx_list[n] = i;
            n++;
         end
      end
      up  = mode[0] ^ ld;
      pre = (~mode[1]) ^ ld;
      if (up) first = pre ? base + 32'd4 : base;
      else    first = pre ? base - 32'(4 * n) : base - 32'(4 * n) + 32'd4;
      wbexp   = up ? base + 32'(4 * n) : base - 32'(4 * n);
      last_rd = '0;

      @(negedge clk);
      start_valid = 1'b1;
      start_base  = base;
      start_mask  = mask;
      start_load  = ld;
      start_mode  = mode;
      start_wback = wb;
      @(negedge clk);
      start_valid = 1'b0;

      while (guard < 400) begin
         if (done) begin
            seen_done = 1;
            if (n == 0) begin
               chk(guard == 0, "R8", "done delay for empty list", guard, 0);
               chk(!mem_req, "R8", "request with empty list", mem_req, 0);
            end
            chk(beats == n, "R2", "accepted beats", beats, n);
            chk(!mem_req, "R7", "request pending at done", mem_req, 0);
            chk(wb_valid == (wb && n != 0), "R5", "wb_valid", wb_valid, wb && n != 0);
            if (wb && n != 0)
               chk(wb_base == wbexp, "R5", "wb_base", wb_base, wbexp);
            chk(branch_valid == (ld && mask[15]), "R9", "branch_valid",
                branch_valid, ld && mask[15]);
            if (ld && mask[15])
               chk(branch_target == last_rd, "R9", "branch_target", branch_target, last_rd);
            break;
         end
         if (mem_req) begin
            if (beats >= n) begin
               chk(0, "R2", "extra request", beats, n);
            end else begin
               chk(mem_reg_idx == 4'(idx_list[beats]), "R2", "register index",
                   mem_reg_idx, idx_list[beats]);
               chk(mem_write == !ld, "R2", "direction", mem_write, !ld);
               if (beats == 0)
                  chk(mem_addr == first, "R4", "first address", mem_addr, first);
               else
                  chk(mem_addr == first + 32'(4 * beats), "R3", "beat address",
                      mem_addr, first + 32'(4 * beats));
            end
            step_lfsr();
            mem_ready = (int'(lfsr[2:0]) < dens);
            mem_rdata = mem_addr ^ 32'h5A5A_0F0F;
            if (mem_ready) begin
               if (mem_reg_idx == 4'd15) last_rd = mem_rdata;
               beats++;
               if (lfsr[5]) begin
                  // R10: stray command while busy must be ignored
                  start_valid = 1'b1;
                  start_base  = base + 32'h100;
                  start_mask  = ~mask;
                  start_load  = ~ld;
               end
            end
         end else begin
            chk(0, "R7", "stalled without request or done", beats, n);
         end
         @(negedge clk);
         mem_ready   = 1'b0;
         start_valid = 1'b0;
         guard++;
      end
      if (!seen_done) chk(0, "R7", "transfer never completed", beats, n);
      @(negedge clk);
      chk(!done, "R7", "done longer than one cycle", done, 0);
   endtask

   initial begin
      logic [15:0] masks [20];
      masks[0] = 16'h0000; masks[1] = 16'hFFFF; masks[2] = 16'h0001;
      masks[3] = 16'h8000; masks[4] = 16'h8001; masks[5] = 16'h4000;
      masks[6] = 16'hAAAA; masks[7] = 16'h5555;
      for (int i = 8; i < 20; i++) begin
         step_lfsr();
         masks[i] = lfsr ^ 16'(i * 16'h1357);
      end

      repeat (3) @(negedge clk);
      chk(!busy && !mem_req && !done, "R1", "idle in reset", {busy, mem_req, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !mem_req && !done && !wb_valid && !branch_valid, "R1",
          "idle after reset", {busy, mem_req, done, wb_valid, branch_valid}, 0);

      for (int m = 0; m < 4; m++) begin
         for (int l = 0; l < 2; l++) begin
            for (int w = 0; w < 2; w++) begin
               for (int k = 0; k < 20; k++) begin
                  step_lfsr();
                  run_xfer({12'h000, lfsr, 4'h0} + 32'h400, masks[k], l[0], m[1:0],
                           w[0], 1 + (k % 8));
               end
            end
         end
      end

      // Stack push then pop on the same base (R4, R5)
      run_xfer(32'h0000_2000, 16'hC00F, 1'b0, 2'b00, 1'b1, 8);
      run_xfer(32'h0000_2000 - 32'd24, 16'hC00F, 1'b1, 2'b00, 1'b1, 3);
      // Base near zero wraps arithmetically (R4)
      run_xfer(32'h0000_0008, 16'h00FF, 1'b0, 2'b10, 1'b1, 5);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule